// File: doc/BRIEF.md
# Command/Response Transaction Sequencer

This block is a host-side bus master that runs one full command/response exchange against a memory-mapped command/response register block over a 32-bit register bus. A pulse on `go` starts the exchange. The block reads the command bytes from a local byte buffer through an index/data port, and it returns the response bytes through a write port together with the response length and a 3-bit result code.

The exchange always runs in the same order:
1. Check the command size and the device error bit.
2. Acquire locality 0.
3. Clear the cancel register.
4. Move the device to idle if it is not idle already, then move it to ready.
5. Copy the command bytes and ring the start register.
6. Poll for completion. If completion times out, fall back to a cancel.
7. Read the response header, validate the big-endian length, read the response body, then return the device to idle and release the locality.

Every poll phase has its own down-counter of clock cycles. The completion timeout is selected from the command code found in the command.

Bus protocol: a transaction is presented on `regReq`/`regWe`/`regAddr`/`regWdata` and held until `regAck`. It completes in the cycle in which both `regReq` and `regAck` are high. Read data is valid on `regRdata` in that cycle.

Register offsets used:

| Register | Offset |
|---|---|
| locality state | 0x00 |
| locality control | 0x08 |
| request | 0x40 |
| status | 0x44 |
| cancel | 0x48 |
| start | 0x4C |
| command size | 0x58 |

The command and response buffers both default to offset 0x80. Each buffer byte is one bus access, carried in bits 7:0.

Top module: `cmd_rsp_seq`

## Requirements
- R1: A `go` pulse while idle raises `busy` in the next cycle. The exchange ends with a one-cycle `done` pulse in which `busy` is low. `errCode` is cleared at `go` and holds its final value until the next `go`. The codes are: 0 none, 1 too big, 2 device error, 3 locality, 4 idle, 5 ready, 6 cancel, 7 bad length.
- R2: The first access reads the command size register. If `cmdLen` is greater than the value read, the exchange ends with code 1 and makes no bus write.
- R3: Next the status register is read. If its bit 0 is set, the exchange ends with code 2 and makes no bus write.
- R4: The block writes 1 to locality control, then polls locality state until bits 7 and 1 are both set. If a failing poll read completes after TIMEOUT_C cycles of that phase, the exchange ends with code 3.
- R5: The block writes 0 to cancel and reads status. If status bit 1 is clear, it writes 2 to request and polls status until bit 1 is set; a timeout gives code 4. It then writes 1 to request and polls status until bit 0 is clear; a timeout gives code 5.
- R6: Command bytes 0 to `cmdLen`-1 are written in order to the command buffer offset plus the byte index. Then 1 is written to start. A request that is not yet acknowledged keeps its address, direction and data.
- R7: The command code is bytes 6 to 9 of the command, read big-endian. A code within [LONG_LO, LONG_HI] uses TIMEOUT_LONG for completion; any other code uses TIMEOUT_SHORT.
- R8: Completion polls start until it reads zero. On a completion timeout the block writes 1 to cancel and polls start for TIMEOUT_B cycles. If start clears, the block writes 0 to cancel and continues. If the cancel also times out, the exchange ends with code 6.
- R9: The block reads 10 header bytes and takes the length from bytes 2 to 5, big-endian. A length below 10 or above MAX_RSP ends the exchange with code 7, and no body byte is read.
- R10: Every response byte read is delivered on `rspWe`/`rspIdx`/`rspByte` with its index. After a successful exchange, `rspLen` equals the header length.
- R11: A successful exchange finishes by writing 2 to request and then 2 to locality control. No error exit makes these writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| go | input | 1 | start one exchange (sampled while idle) |
| cmdLen | input | LEN_W | command length in bytes |
| cmdIdx | output | LEN_W | command buffer byte index |
| cmdByte | input | 8 | command byte at `cmdIdx` (combinational) |
| regReq | output | 1 | bus request |
| regWe | output | 1 | bus write (1) or read (0) |
| regAddr | output | ADDR_W | bus address |
| regWdata | output | 32 | bus write data |
| regAck | input | 1 | bus acknowledge, completes the transaction |
| regRdata | input | 32 | bus read data, valid with `regAck` |
| rspWe | output | 1 | response byte strobe |
| rspIdx | output | LEN_W | response byte index |
| rspByte | output | 8 | response byte |
| rspLen | output | 32 | response length from the header |
| busy | output | 1 | exchange in progress |
| done | output | 1 | one-cycle end-of-exchange pulse |
| errCode | output | 3 | result code |

## Verification
The assertions check the following on every cycle:
- `busy` starts after `go`, and `done` is a single-cycle pulse.
- A pending bus request holds steady until it is acknowledged.
- The poll timer stays at zero once it has run out.
- The byte index moves only on a strobe.
- The body is read only with an accepted length.
- Response bytes appear only while no error is recorded.

The ordering of register writes, the choice between short and long completion timeouts, the cancel fallback and each error exit depend on the device's answers. Only the bench scenarios can show these: they compare every write and every response byte against a behavioural model of the exchange.

// File: rtl/cmd_rsp_seq_pkg.sv
package cmd_rsp_seq_pkg;

  localparam int unsigned OFF_LOC_STATE = 32'h000;
  localparam int unsigned OFF_LOC_CTRL  = 32'h008;
  localparam int unsigned OFF_REQUEST   = 32'h040;
  localparam int unsigned OFF_STATUS    = 32'h044;
  localparam int unsigned OFF_CANCEL    = 32'h048;
  localparam int unsigned OFF_START     = 32'h04C;
  localparam int unsigned OFF_CMD_SIZE  = 32'h058;
  localparam int unsigned HDR_BYTES     = 10;

  typedef enum logic [2:0] {
    ERR_NONE, ERR_TOO_BIG, ERR_DEVICE, ERR_LOCALITY,
    ERR_IDLE, ERR_READY, ERR_CANCEL, ERR_BAD_LEN
  } errCode_e;

  typedef enum logic [1:0] {TMR_C, TMR_B, TMR_CMD} tmrSel_e;

  typedef enum logic [4:0] {
    S_IDLE, S_SIZE, S_STS, S_LOCREQ, S_LOCPOLL, S_CANCLR, S_IDLECHK,
    S_GOIDLE, S_IDLEPOLL, S_GORDY, S_RDYPOLL, S_COPY, S_START, S_STPOLL,
    S_CANSET, S_CANPOLL, S_CANREL, S_HDR, S_BODY, S_REQIDLE, S_RELQ, S_FIN
  } seqState_e;

  typedef struct packed {
    logic    begin_;
    logic    idxClr;
    logic    idxInc;
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    capCode;
    logic    capLen;
  } dpStrobe_t;

endpackage

// File: rtl/cmd_rsp_seq_dpath.sv
module cmd_rsp_seq_dpath
  import cmd_rsp_seq_pkg::*;
#(
  parameter int unsigned LEN_W         = 16,
  parameter int unsigned TMR_W         = 20,
  parameter int unsigned TIMEOUT_C     = 1000,
  parameter int unsigned TIMEOUT_B     = 1000,
  parameter int unsigned TIMEOUT_SHORT = 2000,
  parameter int unsigned TIMEOUT_LONG  = 100000,
  parameter int unsigned LONG_LO       = 32'h100,
  parameter int unsigned LONG_HI       = 32'h1FF,
  parameter int unsigned MAX_RSP       = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        st,
  input  logic [LEN_W-1:0] cmdLenIn,
  input  logic [7:0]       cmdByte,
  input  logic [7:0]       busByte,
  output logic [LEN_W-1:0] idx,
  output logic [LEN_W-1:0] cmdLenQ,
  output logic             tmrZero,
  output logic             lenOk,
  output logic             lastCmd,
  output logic             lastRsp,
  output logic [31:0]      rspLen
);

  localparam logic [LEN_W-1:0] CODE_FIRST = LEN_W'(6);
  localparam logic [LEN_W-1:0] CODE_LAST  = LEN_W'(9);
  localparam logic [LEN_W-1:0] LEN_FIRST  = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_LAST   = LEN_W'(5);

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] tmrLoadVal;
  logic [31:0]      cmdCode;
  logic             longCmd;

  assign longCmd = (cmdCode >= 32'(LONG_LO)) && (cmdCode <= 32'(LONG_HI));

  always_comb begin
    unique case (st.tmrSel)
      TMR_C:   tmrLoadVal = TMR_W'(TIMEOUT_C);
      TMR_B:   tmrLoadVal = TMR_W'(TIMEOUT_B);
      default: tmrLoadVal = longCmd ? TMR_W'(TIMEOUT_LONG) : TMR_W'(TIMEOUT_SHORT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      cmdLenQ <= '0;
      cmdCode <= '0;
      rspLen  <= '0;
      tmr     <= '0;
    end else begin
      if (st.begin_) begin
        cmdLenQ <= cmdLenIn;
        cmdCode <= '0;
        rspLen  <= '0;
      end
      if (st.begin_ || st.idxClr) idx <= '0;
      else if (st.idxInc)         idx <= idx + LEN_W'(1);
      if (st.capCode && idx >= CODE_FIRST && idx <= CODE_LAST)
        cmdCode <= {cmdCode[23:0], cmdByte};
      if (st.capLen && idx >= LEN_FIRST && idx <= LEN_LAST)
        rspLen <= {rspLen[23:0], busByte};
      if (st.tmrLoad)      tmr <= tmrLoadVal;
      else if (tmr != '0)  tmr <= tmr - TMR_W'(1);
    end
  end

  assign tmrZero = (tmr == '0);
  assign lenOk   = (rspLen >= 32'(HDR_BYTES)) && (rspLen <= 32'(MAX_RSP));
  assign lastCmd = ((idx + LEN_W'(1)) == cmdLenQ);
  assign lastRsp = ((32'(idx) + 32'd1) == rspLen);

  // Once expired, the poll timer only restarts through a load (R4, R8).
  assert_tmr_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tmrLoad && tmr == '0) |=> (tmr == '0));

  // The byte index moves only when the controller strobes it (R6, R10).
  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!st.begin_ && !st.idxClr && !st.idxInc) |=> $stable(idx));

endmodule

// File: rtl/cmd_rsp_seq_ctrl.sv
module cmd_rsp_seq_ctrl
  import cmd_rsp_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned CMD_OFF = 32'h080,
  parameter int unsigned RSP_OFF = 32'h080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic              regAck,
  input  logic [31:0]       regRdata,
  input  logic [7:0]        cmdByte,
  input  logic [LEN_W-1:0]  idx,
  input  logic [LEN_W-1:0]  cmdLenQ,
  input  logic              tmrZero,
  input  logic              lenOk,
  input  logic              lastCmd,
  input  logic              lastRsp,
  input  logic [31:0]       rspLen,
  output dpStrobe_t         st,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWdata,
  output logic              rspWe,
  output logic              busy,
  output logic              done,
  output logic [2:0]        errCode
);

  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_BYTES - 1);

  seqState_e state, nextState;
  errCode_e  errQ, errNext;
  logic      acc;

  assign acc     = regReq && regAck;
  assign busy    = (state != S_IDLE) && (state != S_FIN);
  assign done    = (state == S_FIN);
  assign regReq  = busy;
  assign errCode = errQ;
  assign rspWe   = acc && ((state == S_HDR) || (state == S_BODY));

  // Bus request per state.
  always_comb begin
    regWe    = 1'b0;
    regAddr  = '0;
    regWdata = '0;
    unique case (state)
      S_SIZE:                           regAddr = ADDR_W'(OFF_CMD_SIZE);
      S_STS, S_IDLECHK, S_IDLEPOLL,
      S_RDYPOLL:                        regAddr = ADDR_W'(OFF_STATUS);
      S_LOCREQ:   begin regWe = 1'b1; regAddr = ADDR_W'(OFF_LOC_CTRL); regWdata = 32'd1; end
      S_LOCPOLL:                        regAddr = ADDR_W'(OFF_LOC_STATE);
      S_CANCLR, S_CANREL:
                  begin regWe = 1'b1; regAddr = ADDR_W'(OFF_CANCEL);   regWdata = 32'd0; end
      S_GOIDLE, S_REQIDLE:
                  begin regWe = 1'b1; regAddr = ADDR_W'(OFF_REQUEST);  regWdata = 32'd2; end
      S_GORDY:    begin regWe = 1'b1; regAddr = ADDR_W'(OFF_REQUEST);  regWdata = 32'd1; end
      S_COPY:     begin regWe = 1'b1; regAddr = ADDR_W'(CMD_OFF) + ADDR_W'(idx);
                        regWdata = {24'd0, cmdByte}; end
      S_START:    begin regWe = 1'b1; regAddr = ADDR_W'(OFF_START);    regWdata = 32'd1; end
      S_STPOLL, S_CANPOLL:              regAddr = ADDR_W'(OFF_START);
      S_CANSET:   begin regWe = 1'b1; regAddr = ADDR_W'(OFF_CANCEL);   regWdata = 32'd1; end
      S_HDR, S_BODY:                    regAddr = ADDR_W'(RSP_OFF) + ADDR_W'(idx);
      S_RELQ:     begin regWe = 1'b1; regAddr = ADDR_W'(OFF_LOC_CTRL); regWdata = 32'd2; end
      default: ;
    endcase
  end

  // Sequencing and strobes to the datapath.
  always_comb begin
    nextState = state;
    errNext   = errQ;
    st        = '0;
    st.tmrSel = TMR_C;
    unique case (state)
      S_IDLE: if (go) begin
        nextState = S_SIZE; errNext = ERR_NONE; st.begin_ = 1'b1;
      end
      S_SIZE: if (acc) begin
        if (32'(cmdLenQ) > regRdata) begin nextState = S_FIN; errNext = ERR_TOO_BIG; end
        else nextState = S_STS;
      end
      S_STS: if (acc) begin
        if (regRdata[0]) begin nextState = S_FIN; errNext = ERR_DEVICE; end
        else nextState = S_LOCREQ;
      end
      S_LOCREQ: if (acc) begin nextState = S_LOCPOLL; st.tmrLoad = 1'b1; end
      S_LOCPOLL: if (acc) begin
        if (regRdata[7] && regRdata[1]) nextState = S_CANCLR;
        else if (tmrZero) begin nextState = S_FIN; errNext = ERR_LOCALITY; end
      end
      S_CANCLR: if (acc) nextState = S_IDLECHK;
      S_IDLECHK: if (acc) nextState = regRdata[1] ? S_GORDY : S_GOIDLE;
      S_GOIDLE: if (acc) begin nextState = S_IDLEPOLL; st.tmrLoad = 1'b1; end
      S_IDLEPOLL: if (acc) begin
        if (regRdata[1]) nextState = S_GORDY;
        else if (tmrZero) begin nextState = S_FIN; errNext = ERR_IDLE; end
      end
      S_GORDY: if (acc) begin nextState = S_RDYPOLL; st.tmrLoad = 1'b1; end
      S_RDYPOLL: if (acc) begin
        if (!regRdata[0]) begin
          st.idxClr = 1'b1;
          nextState = (cmdLenQ == '0) ? S_START : S_COPY;
        end else if (tmrZero) begin nextState = S_FIN; errNext = ERR_READY; end
      end
      S_COPY: if (acc) begin
        st.capCode = 1'b1; st.idxInc = 1'b1;
        if (lastCmd) nextState = S_START;
      end
      S_START: if (acc) begin
        nextState = S_STPOLL; st.tmrLoad = 1'b1; st.tmrSel = TMR_CMD;
      end
      S_STPOLL: if (acc) begin
        if (regRdata == 32'd0) begin nextState = S_HDR; st.idxClr = 1'b1; end
        else if (tmrZero) nextState = S_CANSET;
      end
      S_CANSET: if (acc) begin
        nextState = S_CANPOLL; st.tmrLoad = 1'b1; st.tmrSel = TMR_B;
      end
      S_CANPOLL: if (acc) begin
        if (regRdata == 32'd0) nextState = S_CANREL;
        else if (tmrZero) begin nextState = S_FIN; errNext = ERR_CANCEL; end
      end
      S_CANREL: if (acc) begin nextState = S_HDR; st.idxClr = 1'b1; end
      S_HDR: if (acc) begin
        st.capLen = 1'b1; st.idxInc = 1'b1;
        if (idx == HDR_LAST) begin
          if (!lenOk) begin nextState = S_FIN; errNext = ERR_BAD_LEN; end
          else if (rspLen == 32'(HDR_BYTES)) nextState = S_REQIDLE;
          else nextState = S_BODY;
        end
      end
      S_BODY: if (acc) begin
        st.idxInc = 1'b1;
        if (lastRsp) nextState = S_REQIDLE;
      end
      S_REQIDLE: if (acc) nextState = S_RELQ;
      S_RELQ:    if (acc) nextState = S_FIN;
      S_FIN:     nextState = S_IDLE;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      errQ  <= ERR_NONE;
    end else begin
      state <= nextState;
      errQ  <= errNext;
    end
  end

  assert_go_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && go) |=> busy);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regAddr) && $stable(regWe) && $stable(regWdata)));

  assert_body_len_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BODY) |-> lenOk);

  assert_rsp_clean_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspWe |-> (errCode == 3'd0));

endmodule

// File: rtl/cmd_rsp_seq.sv
module cmd_rsp_seq
  import cmd_rsp_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned LEN_W         = 16,
  parameter int unsigned TMR_W         = 20,
  parameter int unsigned TIMEOUT_C     = 1000,
  parameter int unsigned TIMEOUT_B     = 1000,
  parameter int unsigned TIMEOUT_SHORT = 2000,
  parameter int unsigned TIMEOUT_LONG  = 100000,
  parameter int unsigned LONG_LO       = 32'h100,
  parameter int unsigned LONG_HI       = 32'h1FF,
  parameter int unsigned MAX_RSP       = 4096,
  parameter int unsigned CMD_OFF       = 32'h080,
  parameter int unsigned RSP_OFF       = 32'h080
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [LEN_W-1:0]  cmdLen,
  output logic [LEN_W-1:0]  cmdIdx,
  input  logic [7:0]        cmdByte,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWdata,
  input  logic              regAck,
  input  logic [31:0]       regRdata,
  output logic              rspWe,
  output logic [LEN_W-1:0]  rspIdx,
  output logic [7:0]        rspByte,
  output logic [31:0]       rspLen,
  output logic              busy,
  output logic              done,
  output logic [2:0]        errCode
);

  dpStrobe_t        st;
  logic [LEN_W-1:0] idx, cmdLenQ;
  logic             tmrZero, lenOk, lastCmd, lastRsp;

  cmd_rsp_seq_dpath #(
    .LEN_W(LEN_W), .TMR_W(TMR_W), .TIMEOUT_C(TIMEOUT_C), .TIMEOUT_B(TIMEOUT_B),
    .TIMEOUT_SHORT(TIMEOUT_SHORT), .TIMEOUT_LONG(TIMEOUT_LONG),
    .LONG_LO(LONG_LO), .LONG_HI(LONG_HI), .MAX_RSP(MAX_RSP)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .cmdLenIn(cmdLen), .cmdByte(cmdByte),
    .busByte(regRdata[7:0]), .idx(idx), .cmdLenQ(cmdLenQ), .tmrZero(tmrZero),
    .lenOk(lenOk), .lastCmd(lastCmd), .lastRsp(lastRsp), .rspLen(rspLen)
  );

  cmd_rsp_seq_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CMD_OFF(CMD_OFF), .RSP_OFF(RSP_OFF)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .go(go), .regAck(regAck), .regRdata(regRdata),
    .cmdByte(cmdByte), .idx(idx), .cmdLenQ(cmdLenQ), .tmrZero(tmrZero),
    .lenOk(lenOk), .lastCmd(lastCmd), .lastRsp(lastRsp), .rspLen(rspLen),
    .st(st), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .rspWe(rspWe), .busy(busy), .done(done),
    .errCode(errCode)
  );

  assign cmdIdx  = idx;
  assign rspIdx  = idx;
  assign rspByte = regRdata[7:0];

endmodule

// File: tb/cmd_rsp_seq_tb_top.sv
module cmd_rsp_seq_tb_top;

  localparam int LEN_W = 16;
  localparam int ADDR_W = 12;
  localparam int MAXR = 64;

  logic clk = 0, rstN = 0, go = 0;
  logic [LEN_W-1:0] cmdLen = '0, cmdIdx, rspIdx;
  logic [7:0] cmdByte, rspByte;
  logic regReq, regWe, regAck, rspWe, busy, done;
  logic [ADDR_W-1:0] regAddr;
  logic [31:0] regWdata, regRdata, rspLen;
  logic [2:0] errCode;

  always #5 clk = ~clk;

  cmd_rsp_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TMR_W(12), .TIMEOUT_C(40), .TIMEOUT_B(40),
    .TIMEOUT_SHORT(30), .TIMEOUT_LONG(300), .LONG_LO(32'h100), .LONG_HI(32'h1FF),
    .MAX_RSP(MAXR), .CMD_OFF(32'h080), .RSP_OFF(32'h080)
  ) dut_i (.*);

  int errs = 0, checks = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Command buffer and response memory seen by the behavioural device.
  logic [7:0] cmdMem [0:63];
  logic [7:0] rspMem [0:127];
  assign cmdByte = cmdMem[cmdIdx[5:0]];

  // Behavioural device.
  logic [31:0] locState, sts, cfgSize, devRdata;
  logic devAck;
  bit startReg, locOk, idleOk, readyBad, cancelOk;
  int startCnt, startDelay;
  assign regAck = devAck;
  assign regRdata = devRdata;

  always @(posedge clk) begin
    if (!rstN) begin
      devAck <= 0; devRdata <= '0;
    end else begin
      if (startReg && startCnt > 0) begin
        startCnt--;
        if (startCnt == 0) startReg = 0;
      end
      if (regReq && !devAck) begin
        devAck <= 1;
        if (regWe) begin
          case (regAddr)
            12'h008: if (regWdata == 1 && locOk) locState = 32'h82;
                     else if (regWdata == 2) locState = 0;
            12'h040: if (regWdata == 2 && idleOk) sts[1] = 1;
                     else if (regWdata == 1) begin sts[1] = 0; if (readyBad) sts[0] = 1; end
            12'h04C: if (regWdata == 1) begin startReg = 1; startCnt = startDelay; end
            12'h048: if (regWdata == 1 && cancelOk) startReg = 0;
            default: ;
          endcase
        end else begin
          case (regAddr)
            12'h000: devRdata <= locState;
            12'h044: devRdata <= sts;
            12'h04C: devRdata <= {31'd0, startReg};
            12'h058: devRdata <= cfgSize;
            default: devRdata <= (regAddr >= 12'h080) ? {24'd0, rspMem[regAddr - 12'h080]} : 32'd0;
          endcase
        end
      end else devAck <= 0;
    end
  end

  // Reference model: expected writes, response bytes and busy, compared every cycle.
  logic [43:0] expW[$];
  bit inFlight = 0, doneSeen = 0;
  int rspCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin inFlight = 0; doneSeen = 1; end
      check(busy === inFlight, "R1 busy", busy, inFlight);
      if (regReq && regAck && regWe) begin
        if (expW.size() == 0) check(0, "R6/R11 unexpected write", {regAddr, regWdata}, 0);
        else begin
          logic [43:0] e;
          e = expW.pop_front();
          check({regAddr, regWdata} == e, "R6/R11 write order", {regAddr, regWdata}, e);
        end
      end
      if (rspWe) begin
        check(rspByte == rspMem[rspIdx[6:0]] && rspIdx == LEN_W'(rspCount),
              "R10 rsp byte", {rspIdx, rspByte}, {rspCount[15:0], rspMem[rspCount[6:0]]});
        rspCount++;
      end
    end
  end

  task automatic pushW(input int a, input int d);
    expW.push_back({a[11:0], d});
  endtask

  task automatic setup(input int len, input int code, input int rlen);
    cfgSize = 32; locState = 0; sts = 0; startReg = 0; startCnt = 0; startDelay = 5;
    locOk = 1; idleOk = 1; readyBad = 0; cancelOk = 1;
    for (int i = 0; i < 64; i++) cmdMem[i] = 8'(i * 7 + 3);
    cmdMem[6] = 8'(code >> 24); cmdMem[7] = 8'(code >> 16);
    cmdMem[8] = 8'(code >> 8);  cmdMem[9] = 8'(code);
    for (int i = 0; i < 128; i++) rspMem[i] = 8'(i ^ 8'h5A);
    rspMem[2] = 8'(rlen >> 24); rspMem[3] = 8'(rlen >> 16);
    rspMem[4] = 8'(rlen >> 8);  rspMem[5] = 8'(rlen);
    cmdLen = LEN_W'(len);
    expW.delete(); rspCount = 0; doneSeen = 0;
  endtask

  task automatic pushPrefix(input bit idleInit);
    pushW('h08, 1); pushW('h48, 0);
    if (!idleInit) pushW('h40, 2);
    pushW('h40, 1);
  endtask

  task automatic pushCmd(input int len);
    for (int i = 0; i < len; i++) pushW('h80 + i, cmdMem[i]);
    pushW('h4C, 1);
  endtask

  task automatic run(input string req, input int expErr, input int expBytes, input int expLen);
    @(posedge clk); #1 go = 1;
    @(posedge clk); #1 go = 0; inFlight = 1;
    while (!doneSeen) @(negedge clk);
    @(negedge clk);
    check(errCode == 3'(expErr), req, errCode, expErr);
    check(expW.size() == 0, {req, " all writes seen"}, expW.size(), 0);
    check(rspCount == expBytes, {req, " rsp byte count"}, rspCount, expBytes);
    if (expErr == 0) check(rspLen == 32'(expLen), {req, " R10 rspLen"}, rspLen, expLen);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    setup(12, 'h42, 14);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(!busy && !done && !regReq && errCode == 0, "R1 reset state", {busy, done, regReq, errCode}, 0);

    // R6 R7 R10 R11: short command, device already idle, fast completion.
    setup(12, 'h42, 14); sts[1] = 1;
    pushPrefix(1); pushCmd(12); pushW('h40, 2); pushW('h08, 2);
    run("R11 success short", 0, 14, 14);

    // R5 R9: go-idle needed, long code, header-only response.
    setup(10, 'h150, 10); sts[1] = 0; startDelay = 100;
    pushPrefix(0); pushCmd(10); pushW('h40, 2); pushW('h08, 2);
    run("R7 long timeout no cancel", 0, 10, 10);

    // R7 R8: short code with slow device takes the cancel path.
    setup(10, 'h42, 20); sts[1] = 1; startDelay = 100;
    pushPrefix(1); pushCmd(10); pushW('h48, 1); pushW('h48, 0); pushW('h40, 2); pushW('h08, 2);
    run("R8 cancel recovers", 0, 20, 20);

    setup(40, 'h42, 14); cfgSize = 32;
    run("R2 too big", 1, 0, 0);

    setup(32, 'h42, 14); cfgSize = 32; sts[1] = 1;
    pushPrefix(1); pushCmd(32); pushW('h40, 2); pushW('h08, 2);
    run("R2 length equal to size accepted", 0, 14, 14);

    setup(12, 'h42, 14); sts[0] = 1;
    run("R3 device error", 2, 0, 0);

    setup(12, 'h42, 14); locOk = 0;
    pushW('h08, 1);
    run("R4 locality timeout", 3, 0, 0);

    setup(12, 'h42, 14); idleOk = 0;
    pushW('h08, 1); pushW('h48, 0); pushW('h40, 2);
    run("R5 idle timeout", 4, 0, 0);

    setup(12, 'h42, 14); sts[1] = 1; readyBad = 1;
    pushW('h08, 1); pushW('h48, 0); pushW('h40, 1);
    run("R5 ready timeout", 5, 0, 0);

    setup(12, 'h42, 14); sts[1] = 1; startDelay = 100000; cancelOk = 0;
    pushPrefix(1); pushCmd(12); pushW('h48, 1);
    run("R8 cancel timeout", 6, 0, 0);

    setup(12, 'h42, 5); sts[1] = 1;
    pushPrefix(1); pushCmd(12);
    run("R9 length below header", 7, 10, 0);

    setup(12, 'h42, 100); sts[1] = 1;
    pushPrefix(1); pushCmd(12);
    run("R9 length above max", 7, 10, 0);

    setup(12, 'h42, MAXR); sts[1] = 1;
    pushPrefix(1); pushCmd(12); pushW('h40, 2); pushW('h08, 2);
    run("R9 length at max accepted", 0, MAXR, MAXR);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule